// File: doc/BRIEF.md
# Residue Triple Quotient Extractor

This block takes one operand held as three residues over the pairwise coprime moduli 2^N−1, 2^N and 2^N+1, and returns the integer quotient of that operand by 2^N. The quotient is formed directly from the residues, without rebuilding the binary value first. The operand X lies in [0, M−1] with M = 2^N·(2^(2N)−1), so the quotient lies in [0, 2^(2N)−2] and satisfies X = 2^N·quo + res_mid. A later stage can add two such quotients to judge whether a residue-domain sum has wrapped past M. It can also add the two middle residues to rebuild the true sum.

Four 2N-bit terms are formed by wiring alone: bit rotations, placement, and one's complement for negation modulo 2^(2N)−1. Two carry-save stages compress them, and each stage wraps its carry vector around end to end. Two full-width adders run side by side, one computing s+c and one computing s+c+1. A select picks the result that carries the modular reduction. An all-ones result is folded to zero. The quotient is captured in one output register, so the result appears one clock edge after the residues are presented.

Top module: `rns_rho_extract`

## Requirements
- R1: When rst_n is low at a rising clock edge, quo reads 0 after that edge, whatever the residue inputs are.
- R2: For a canonical operand the block computes floor(X / 2^N) as a 2N-bit value and presents it on quo after the next rising edge. An operand is canonical when res_lo = X mod (2^N−1), res_mid = X mod 2^N and res_hi = X mod (2^N+1), for X in [0, M−1].
- R3: For canonical inputs, quo never takes the all-ones value 2^(2N)−1. The largest operand X = M−1 gives quo = 2^(2N)−2.
- R4: A canonical operand whose res_hi equals 2^N (bit N set, all lower bits clear) yields the correct quotient. For such an operand, quo mod (2^N+1) equals (res_mid + 1) mod (2^N+1).
- R5: For canonical inputs, quo mod (2^N−1) equals (res_lo − res_mid) mod (2^N−1), taken from the inputs at the previous edge.
- R6: For canonical inputs, quo mod (2^N+1) equals (res_mid − res_hi) mod (2^N+1), taken from the inputs at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset; clears quo |
| res_lo | input | N | Residue modulo 2^N−1, canonical range [0, 2^N−2] |
| res_mid | input | N | Residue modulo 2^N |
| res_hi | input | N+1 | Residue modulo 2^N+1, canonical range [0, 2^N] |
| quo | output | 2N | Registered quotient floor(X / 2^N) |

## Verification
The modular-consistency and range properties assume that each residue is canonical: res_lo never equals 2^N−1 and res_hi never exceeds 2^N. Each property is gated by that condition, so a non-canonical input disables the check instead of tripping it. The stimulus never leaves the canonical set. Every input triple is produced by reducing one integer drawn from [0, M−1] by the three moduli, whether that integer comes from the exhaustive sweep, the seeded random draws or the directed corner values (zero, M−1, res_hi = 2^N).

// File: rtl/rns_rho_pkg.sv
// Shared types for the residue quotient extractor.
// Holds the select encoding used by the end-around adder pair.
package rns_rho_pkg;

    // Which of the two parallel adder results is forwarded.
    typedef enum logic {
        SEL_PLAIN = 1'b0,   // s + c already below 2^W - 1
        SEL_WRAP  = 1'b1    // s + c + 1 crossed 2^W: take the wrapped value
    } rho_sel_e;

endpackage

// File: rtl/rns_rho_terms.sv
// Operand term former.
// Builds the four 2N-bit terms whose sum modulo 2^(2N)-1 is the quotient.
//   term_a :  2^(N-1)*(2^N+1)*res_lo  -> {res_lo,res_lo} rotated left by N-1
//   term_b : -2^N*res_mid             -> {~res_mid, all ones}
//   term_c : -2^(2N-1)*res_hi         -> complement of res_hi rotated right by 1
//   term_d :  2^(N-1)*res_hi          -> res_hi shifted left by N-1 (no wrap)
// Assumes N >= 2 and res_hi <= 2^N. Pure wiring and inversion, no arithmetic.
module rns_rho_terms #(
    parameter int N = 4
) (
    input  logic [N-1:0]   res_lo,
    input  logic [N-1:0]   res_mid,
    input  logic [N:0]     res_hi,
    output logic [2*N-1:0] term_a,
    output logic [2*N-1:0] term_b,
    output logic [2*N-1:0] term_c,
    output logic [2*N-1:0] term_d
);
    localparam int W     = 2 * N;
    localparam int PAD_H = W - N - 1;

    logic [W-1:0] lo_pair;
    logic [W-1:0] hi_wide;

    // Duplicate the low residue and widen the high residue to the word size.
    assign lo_pair = {res_lo, res_lo};
    assign hi_wide = {{PAD_H{1'b0}}, res_hi};

    // Negating 2^N*res_mid modulo 2^W-1 is the complement of {res_mid, zeros}.
    assign term_b = {~res_mid, {N{1'b1}}};

    // Per-bit routing for the rotated and shifted terms.
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int ROT_A = (i + N - 1) % W;
        localparam int ROT_C = (i + 1) % W;

        assign term_a[ROT_A] = lo_pair[i];
        assign term_c[i]     = ~hi_wide[ROT_C];

        if (i >= N - 1) begin : g_shift
            assign term_d[i] = hi_wide[i - (N - 1)];
        end else begin : g_zero
            assign term_d[i] = 1'b0;
        end
    end

endmodule

// File: rtl/rns_rho_csa.sv
// End-around carry-save stage.
// Compresses three W-bit words into a sum word and a carry word. The carry
// out of the top bit re-enters at bit 0, so the pair keeps the value of the
// three inputs modulo 2^W-1 exactly and never grows in width.
// Assumes W >= 2.
module rns_rho_csa #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] out_sum,
    output logic [W-1:0] out_car
);
    logic [W-1:0] maj;

    // Bitwise full-adder sum and majority carry.
    assign out_sum = in_a ^ in_b ^ in_c;
    assign maj     = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);

    // Carry weight doubles; the top carry wraps to weight 1 (2^W == 1).
    assign out_car = {maj[W-2:0], maj[W-1]};

endmodule

// File: rtl/rns_rho_modadd.sv
// Modulo 2^W-1 carry-propagate adder.
// Two full-width adders run side by side: one forms s+c, the other s+c+1.
// When s+c+1 reaches 2^W the wrapped low bits of s+c+1 are the residue,
// otherwise s+c is already below the modulus. The only remaining
// non-canonical value, all ones (both inputs all ones), is folded to zero.
// Assumes W >= 2. Output range is [0, 2^W-2].
module rns_rho_modadd
    import rns_rho_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] op_s,
    input  logic [W-1:0] op_c,
    output logic [W-1:0] res
);
    logic [W:0]   sum_plain;
    logic [W:0]   sum_inc;
    logic [W-1:0] picked;
    rho_sel_e     sel;

    // Parallel adders: no dependency between them, so one adder delay.
    assign sum_plain = {1'b0, op_s} + {1'b0, op_c};
    assign sum_inc   = {1'b0, op_s} + {1'b0, op_c} + {{W{1'b0}}, 1'b1};

    // Carry out of the incremented adder decides whether the wrap applies.
    assign sel = sum_inc[W] ? SEL_WRAP : SEL_PLAIN;

    // Forward the chosen adder result.
    always_comb begin
        unique case (sel)
            SEL_WRAP:  picked = sum_inc[W-1:0];
            default:   picked = sum_plain[W-1:0];
        endcase
    end

    // All ones is the second encoding of zero modulo 2^W-1.
    assign res = (&picked) ? '0 : picked;

endmodule

// File: rtl/rns_rho_extract.sv
// Residue triple quotient extractor (top).
// Given canonical residues of X over {2^N-1, 2^N, 2^N+1}, registers
// quo = floor(X / 2^N) one clock edge after the residues are presented.
// Datapath: term former -> chain of end-around carry-save stages ->
// modulo 2^(2N)-1 adder pair -> output register.
// Assumes N >= 2, res_lo <= 2^N-2 and res_hi <= 2^N; other codes give an
// unspecified quotient. Synchronous active-low reset clears quo.
module rns_rho_extract #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   res_lo,
    input  logic [N-1:0]   res_mid,
    input  logic [N:0]     res_hi,
    output logic [2*N-1:0] quo
);
    localparam int W         = 2 * N;
    localparam int NUM_TERMS = 4;
    localparam int NUM_CSA   = NUM_TERMS - 2;

    logic [W-1:0] terms [NUM_TERMS];
    logic [W-1:0] acc_s [NUM_CSA + 1];
    logic [W-1:0] acc_c [NUM_CSA + 1];
    logic [W-1:0] quo_next;

    // Form the four wired terms.
    rns_rho_terms #(
        .N (N)
    ) u_terms (
        .res_lo  (res_lo),
        .res_mid (res_mid),
        .res_hi  (res_hi),
        .term_a  (terms[0]),
        .term_b  (terms[1]),
        .term_c  (terms[2]),
        .term_d  (terms[3])
    );

    // Seed the compression chain with the first two terms.
    assign acc_s[0] = terms[0];
    assign acc_c[0] = terms[1];

    // One end-around carry-save stage per remaining term.
    for (genvar k = 0; k < NUM_CSA; k++) begin : g_csa
        rns_rho_csa #(
            .W (W)
        ) u_csa (
            .in_a    (acc_s[k]),
            .in_b    (acc_c[k]),
            .in_c    (terms[k + 2]),
            .out_sum (acc_s[k + 1]),
            .out_car (acc_c[k + 1])
        );
    end

    // Resolve the final sum/carry pair modulo 2^W-1.
    rns_rho_modadd #(
        .W (W)
    ) u_modadd (
        .op_s (acc_s[NUM_CSA]),
        .op_c (acc_c[NUM_CSA]),
        .res  (quo_next)
    );

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo <= '0;
        end else begin
            quo <= quo_next;
        end
    end

endmodule

// File: rtl/rns_rho_extract_chk.sv
// Property checker for rns_rho_extract, attached by bind.
// Checks reset clearing, the output range, and the two modular identities
// the quotient must satisfy against the residues of the previous cycle.
// Data properties are gated on canonical residues.
module rns_rho_extract_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   res_lo,
    input logic [N-1:0]   res_mid,
    input logic [N:0]     res_hi,
    input logic [2*N-1:0] quo
);
    localparam int W = 2 * N;
    localparam logic [W:0] MOD_LO = (W+1)'((1 << N) - 1);
    localparam logic [W:0] MOD_HI = (W+1)'((1 << N) + 1);
    localparam logic [W:0] HI_TOP = (W+1)'(1 << N);

    logic [W:0] lo_w, mid_w, hi_w, quo_w;
    logic [W:0] want_lo, want_hi, want_fold, quo_lo, quo_hi;
    logic       legal;

    // Widen everything to one arithmetic width.
    assign lo_w  = (W+1)'(res_lo);
    assign mid_w = (W+1)'(res_mid);
    assign hi_w  = (W+1)'(res_hi);
    assign quo_w = (W+1)'(quo);

    // Canonical-input guard and expected residues of the quotient.
    assign legal     = (lo_w < MOD_LO) && (hi_w <= HI_TOP);
    assign want_lo   = (lo_w + MOD_LO - (mid_w % MOD_LO)) % MOD_LO;
    assign want_hi   = (mid_w + MOD_HI - hi_w) % MOD_HI;
    assign want_fold = (mid_w + (W+1)'(1)) % MOD_HI;
    assign quo_lo    = quo_w % MOD_LO;
    assign quo_hi    = quo_w % MOD_HI;

    // R1: a reset edge leaves the output cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (quo == '0));

    // R3: the redundant all-ones code never appears.
    p_never_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(legal) |-> !(&quo));

    // R4: high residue equal to 2^N still gives the right residue mod 2^N+1.
    p_hi_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        legal && (hi_w == HI_TOP) |=> (quo_hi == $past(want_fold)));

    // R5: quotient agrees with the low residues modulo 2^N-1.
    p_mod_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        legal |=> (quo_lo == $past(want_lo)));

    // R6: quotient agrees with the residues modulo 2^N+1.
    p_mod_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        legal |=> (quo_hi == $past(want_hi)));

endmodule

bind rns_rho_extract rns_rho_extract_chk #(
    .N (N)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .res_lo  (res_lo),
    .res_mid (res_mid),
    .res_hi  (res_hi),
    .quo     (quo)
);

// File: tb/sim_rns_rho_extract.sv
// Bench for rns_rho_extract: three widths (N = 4, 2, 3) driven together.
// Exhaustive sweep, seeded random draws and directed corners, all checked
// against floor(X / 2^N) computed here from the integer operand.
module sim_rns_rho_extract;
    localparam int CLK_PERIOD = 10;
    localparam int M4 = 16 * 255;
    localparam int M2 = 4 * 15;
    localparam int M3 = 8 * 63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [3:0] lo0, mid0;  logic [4:0] hi0;  logic [7:0] q0;
    logic [1:0] lo1, mid1;  logic [2:0] hi1;  logic [3:0] q1;
    logic [2:0] lo2, mid2;  logic [3:0] hi2;  logic [5:0] q2;

    int n_chk = 0;
    int n_bad = 0;
    int xa, xb, xc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rns_rho_extract #(.N(4)) u0 (
        .clk(clk), .rst_n(rst_n), .res_lo(lo0), .res_mid(mid0), .res_hi(hi0), .quo(q0));
    rns_rho_extract #(.N(2)) u1 (
        .clk(clk), .rst_n(rst_n), .res_lo(lo1), .res_mid(mid1), .res_hi(hi1), .quo(q1));
    rns_rho_extract #(.N(3)) u2 (
        .clk(clk), .rst_n(rst_n), .res_lo(lo2), .res_mid(mid2), .res_hi(hi2), .quo(q2));

    // Record one check; report a mismatch.
    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reduce each operand by its three moduli and drive the residues.
    task automatic drive(int a, int b, int c);
        xa = a; xb = b; xc = c;
        lo0 = 4'(a % 15); mid0 = 4'(a % 16); hi0 = 5'(a % 17);
        lo1 = 2'(b % 3);  mid1 = 2'(b % 4);  hi1 = 3'(b % 5);
        lo2 = 3'(c % 7);  mid2 = 3'(c % 8);  hi2 = 4'(c % 9);
    endtask

    // Quotient and all-ones checks for every width (R2, R3, R4).
    task automatic verify();
        chk((xa % 17 == 16) ? "R4" : "R2", "n4 quotient", int'(q0), xa >> 4);
        chk((xb % 5 == 4)   ? "R4" : "R2", "n2 quotient", int'(q1), xb >> 2);
        chk((xc % 9 == 8)   ? "R4" : "R2", "n3 quotient", int'(q2), xc >> 3);
        chk("R3", "n4 not all ones", int'(q0 == 8'hFF), 0);
        chk("R3", "n2 not all ones", int'(q1 == 4'hF), 0);
        chk("R3", "n3 not all ones", int'(q2 == 6'h3F), 0);
    endtask

    // Apply at a falling edge, sample at the next falling edge.
    task automatic run(int a, int b, int c);
        drive(a, b, c);
        @(negedge clk);
        verify();
    endtask

    // Modular identities on the N=2 instance after a run (R5, R6).
    task automatic mod_checks();
        chk("R5", "n2 quo mod 3", int'(q1) % 3, (xb % 3 - xb % 4 % 3 + 6) % 3);
        chk("R6", "n2 quo mod 5", int'(q1) % 5, (xb % 4 - xb % 5 + 5) % 5);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        // R1: reset with nonzero operands on the inputs.
        drive(4079, 49, 503);
        repeat (2) @(negedge clk);
        chk("R1", "n4 reset value", int'(q0), 0);
        chk("R1", "n2 reset value", int'(q1), 0);
        chk("R1", "n3 reset value", int'(q2), 0);
        rst_n = 1'b1;

        // Directed corners.
        run(0, 0, 0);
        run(M4 - 1, M2 - 1, M3 - 1);
        chk("R3", "n4 maximum", int'(q0), 254);
        chk("R3", "n2 maximum", int'(q1), 14);
        chk("R3", "n3 maximum", int'(q2), 62);
        run(16, 4, 8);                     // R4: high residue = 2^N
        chk("R4", "n2 hi=4 quotient", int'(q1), 1);
        run(33, 49, 17);  mod_checks(); chk("R2", "n2 X=49", int'(q1), 12);
        run(50, 21, 26);  mod_checks(); chk("R2", "n2 X=21", int'(q1), 5);
        run(101, 28, 35); mod_checks(); chk("R2", "n2 X=28", int'(q1), 7);
        run(152, 32, 44); mod_checks(); chk("R2", "n2 X=32", int'(q1), 8);
        run(203, 10, 53); mod_checks(); chk("R2", "n2 X=10", int'(q1), 2);

        // Exhaustive sweep of N=4; smaller widths cycle through their range.
        for (int i = 0; i < M4; i++) begin
            run(i, i % M2, i % M3);
            if (i < M2) mod_checks();
        end

        // Seeded random operands.
        for (int i = 0; i < 1500; i++) begin
            run(int'($urandom % M4), int'($urandom % M2), int'($urandom % M3));
        end

        // R1: reset in mid-run clears the output, then operation resumes.
        drive(1234, 59, 400);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "n4 mid-run reset", int'(q0), 0);
        chk("R1", "n2 mid-run reset", int'(q1), 0);
        chk("R1", "n3 mid-run reset", int'(q2), 0);
        rst_n = 1'b1;
        run(1234, 59, 400);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule